// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache Controller

This block places a one-word-per-line, direct-mapped cache between a multicycle processor and a slow main memory. Reads that find their word in the cache complete in the cycle they are presented. Reads that miss stall the processor while the word is fetched from memory and installed. Stores always update the cache line and are then written through to memory, and the processor stays stalled until that memory write has finished.

The controller is a four-state machine:
- `ST_IDLE` accepts requests.
- `ST_FILL` waits on a memory read.
- `ST_WTHRU` waits on a memory write.
- `ST_DONE` is the one completion cycle after either wait.

The transitions are:
- idle→fill on a read miss.
- idle→wthru on any store.
- fill→done and wthru→done on memory completion.
- done→idle always.

A read hit stays in idle.

Each line holds a valid flag, a tag and a data word. The index width is a parameter. The tag width is the address width minus the index width minus two offset bits.

Top module: `wtc_cache`

## Requirements
- R1: Address bits 1:0 are a byte offset and take no part in the lookup. Bits IDX_W+1:2 select the line, and the bits above them form the tag. Any offset within a cached word hits that word.
- R2: Reset invalidates every line, so the first read of any address after reset misses.
- R3: A read hits when the selected line is valid and its tag equals the address tag. A hit completes in the request cycle with cpu_stall low, the stored word on cpu_rdata, and no memory request.
- R4: A read miss holds cpu_stall high in the request cycle. It then raises mem_req with mem_we low and the word-aligned address until mem_done, which the memory gives in the fifth request cycle. The access completes in the following cycle with the memory word on cpu_rdata and cpu_stall low.
- R5: A read miss installs the returned word, the address tag and a set valid flag, so the next read of that word hits.
- R6: Two addresses with the same index and different tags evict each other. After one is filled, a read of the other misses.
- R7: Every store overwrites the selected line with the store data and address tag and sets its valid flag, whether it hit or missed. A later read of that word hits and returns the store data.
- R8: Every store raises mem_req with mem_we high, the word-aligned address and the store data, all held stable until mem_done. cpu_stall stays high from the request cycle to mem_done and drops in the following cycle, so the store completes with the same timing as a miss.
- R9: While a miss or store is in progress, new processor requests are not accepted. With no request, cpu_stall and mem_req stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data, valid in the completion cycle |
| cpu_stall | output | 1 | High while the access is not yet complete |
| mem_req | output | 1 | Memory access request, held until mem_done |
| mem_we | output | 1 | Memory write select |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_done |
| mem_done | input | 1 | One-cycle memory completion pulse |

## Verification
The assertions assume a processor that holds its request, address and data steady while cpu_stall is high. They also assume a memory that pulses mem_done once per access, and only while mem_req is high. The stimulus task drives a request only at a falling edge and holds it until it sees cpu_stall low. The memory model counts consecutive request cycles and raises mem_done only on the fifth. The address sequence covers same-index conflicts, offset aliases, stores that hit and stores that miss, and a sweep of every index.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WTHRU = 2'd2,
        ST_DONE  = 2'd3
    } wtc_state_e;
endpackage

// File: rtl/wtc_line_store.sv
// Per-line valid flag, tag and data word; combinational read, synchronous write.
module wtc_line_store #(
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 24,
    parameter int DATA_W = 32,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DEPTH-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                tag_q[g]  <= wr_tag;
                data_q[g] <= wr_data;
            end
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wtc_tag_match.sv
module wtc_tag_match #(
    parameter int TAG_W = 24
) (
    input  logic             line_valid,
    input  logic [TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0] req_tag,
    output logic             hit
);
    assign hit = line_valid && (line_tag == req_tag);
endmodule

// File: rtl/wtc_seq.sv
// Controller sequence: accept, fill, write-through, complete.
module wtc_seq
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 2,
    localparam int WORD_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [WORD_W-1:0] cpu_word,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic              mem_done,
    input  logic [DATA_W-1:0] mem_rdata,
    output wtc_state_e        state_o,
    output logic              use_lat,
    output logic [WORD_W-1:0] lat_word,
    output logic              arr_we,
    output logic [WORD_W-1:0] arr_word,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    wtc_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && cpu_req) begin
            word_q  <= cpu_word;
            wdata_q <= cpu_wdata;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && cpu_we)      state_d = ST_WTHRU;
                else if (cpu_req && !hit)   state_d = ST_FILL;
            end
            ST_FILL:  if (mem_done) state_d = ST_DONE;
            ST_WTHRU: if (mem_done) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        arr_we    = 1'b0;
        arr_word  = cpu_word;
        arr_wdata = cpu_wdata;
        use_lat   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                use_lat = 1'b0;
                if (cpu_req && cpu_we) begin
                    cpu_stall = 1'b1;
                    arr_we    = 1'b1;
                end else if (cpu_req && !hit) begin
                    cpu_stall = 1'b1;
                end
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_done) begin
                    arr_we    = 1'b1;
                    arr_word  = word_q;
                    arr_wdata = mem_rdata;
                end
            end
            ST_WTHRU: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
            end
            ST_DONE: ;
        endcase
    end

    assign state_o   = state_q;
    assign lat_word  = word_q;
    assign mem_addr  = {word_q, {OFF_W{1'b0}}};
    assign mem_wdata = wdata_q;

    // R8: memory request fields stay put until the memory completes
    a_r8_mem_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_done) |=> (mem_req && $stable(mem_addr)
                                    && $stable(mem_we) && $stable(mem_wdata)));

    // R4: completion releases the memory request
    a_r4_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        mem_done |=> !mem_req);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 6,
    localparam int OFF_W  = 2,
    localparam int WORD_W = ADDR_W - OFF_W,
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_done
);
    wtc_state_e        state;
    logic              use_lat, arr_we, hit, line_valid;
    logic [WORD_W-1:0] lat_word, arr_word, lk_word, cpu_word;
    logic [DATA_W-1:0] arr_wdata;
    logic [TAG_W-1:0]  line_tag;

    assign cpu_word = cpu_addr[ADDR_W-1:OFF_W];
    assign lk_word  = use_lat ? lat_word : cpu_word;

    wtc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_word[IDX_W-1:0]),
        .rd_valid (line_valid),
        .rd_tag   (line_tag),
        .rd_data  (cpu_rdata),
        .wr_en    (arr_we),
        .wr_idx   (arr_word[IDX_W-1:0]),
        .wr_tag   (arr_word[WORD_W-1:IDX_W]),
        .wr_data  (arr_wdata)
    );

    wtc_tag_match #(.TAG_W(TAG_W)) u_match (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .req_tag    (lk_word[WORD_W-1:IDX_W]),
        .hit        (hit)
    );

    wtc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_word  (cpu_word),
        .cpu_wdata (cpu_wdata),
        .hit       (hit),
        .mem_done  (mem_done),
        .mem_rdata (mem_rdata),
        .state_o   (state),
        .use_lat   (use_lat),
        .lat_word  (lat_word),
        .arr_we    (arr_we),
        .arr_word  (arr_word),
        .arr_wdata (arr_wdata),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // R5: after a fill (or a store) the completing line must hit in the array
    a_r5_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> hit);

    // R7: a store has installed its line before the write-through wait
    a_r7_store_allocates: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WTHRU) |-> hit);

    // R4: memory traffic only follows a stalled request cycle
    a_r4_stall_before_mem: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(cpu_stall));
endmodule

// File: tb/wtc_cache_bench.sv
`timescale 1ns/1ps
module wtc_cache_bench;
    localparam int BIDX = 4;
    localparam int LAT  = 5;
    localparam int NLINE = 1 << BIDX;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata, mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        cpu_stall, mem_req, mem_we, mem_done;

    int vectors = 0;
    int errors  = 0;
    bit ended   = 0;

    always #2 clk = ~clk;

    wtc_cache #(.IDX_W(BIDX)) u_wtc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done)
    );

    function automatic logic [31:0] dflt(input logic [29:0] w);
        return ({2'b00, w} * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    // Behavioural main memory with fixed latency
    logic [31:0] mem_store [logic [29:0]];
    int          mcnt = 0;
    logic [31:0] rd_q = '0;
    assign mem_done  = mem_req && (mcnt == LAT - 1);
    assign mem_rdata = rd_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            mcnt <= 0;
        end else begin
            if (mem_req && mcnt == LAT - 2)
                rd_q <= mem_store.exists(mem_addr[31:2]) ? mem_store[mem_addr[31:2]]
                                                          : dflt(mem_addr[31:2]);
            if (mem_done && mem_we) mem_store[mem_addr[31:2]] = mem_wdata;
            mcnt <= (mem_req && !mem_done) ? mcnt + 1 : 0;
        end
    end

    // Reference model
    bit          ref_v [NLINE];
    logic [25:0] ref_t [NLINE];
    logic [31:0] ref_d [NLINE];
    logic [31:0] ref_mem [logic [29:0]];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr,
                          input logic [31:0] wd, input string req);
        int          idx  = int'(addr[BIDX+1:2]);
        logic [25:0] tg   = addr[31:BIDX+2];
        bit          hit  = !we && ref_v[idx] && (ref_t[idx] == tg);
        int          nst  = hit ? 0 : LAT + 1;
        logic [31:0] expd = hit ? ref_d[idx]
                          : (ref_mem.exists(addr[31:2]) ? ref_mem[addr[31:2]] : dflt(addr[31:2]));
        int  cyc = 0;
        bit  fin = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        while (!fin) begin
            bit xs, xm;
            #1;
            xs = (cyc < nst);
            xm = !hit && cyc >= 1 && cyc <= LAT;
            chk(cpu_stall == xs, req, $sformatf("stall cyc %0d", cyc), 32'(cpu_stall), 32'(xs));
            chk(mem_req == xm, req, $sformatf("mem_req cyc %0d", cyc), 32'(mem_req), 32'(xm));
            if (xm) begin
                chk(mem_we == we, req, "mem_we", 32'(mem_we), 32'(we));
                chk(mem_addr == {addr[31:2], 2'b00}, req, "mem_addr", mem_addr, {addr[31:2], 2'b00});
                if (we) chk(mem_wdata == wd, req, "mem_wdata", mem_wdata, wd);
            end
            if (!xs || !cpu_stall) begin
                if (!we) chk(cpu_rdata == expd, req, "rdata", cpu_rdata, expd);
                fin = 1;
            end else begin
                @(negedge clk);
                cyc++;
                if (cyc > 3 * LAT) begin
                    chk(1'b0, req, "no completion", 32'(cyc), 32'(nst));
                    fin = 1;
                end
            end
        end
        ref_v[idx] = 1'b1;
        ref_t[idx] = tg;
        ref_d[idx] = we ? wd : expd;
        if (we) ref_mem[addr[31:2]] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        chk(!cpu_stall && !mem_req, "R9", "idle outputs", {30'd0, cpu_stall, mem_req}, 32'd0);
    endtask

    localparam logic [31:0] SPAN = 32'(1) << (BIDX + 2);

    initial begin
        for (int i = 0; i < NLINE; i++) ref_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!cpu_stall && !mem_req, "R9", "reset state", {30'd0, cpu_stall, mem_req}, 32'd0);
        access(1'b0, 32'h0000_1010, '0, "R2");          // cold miss
        access(1'b0, 32'h0000_1013, '0, "R1");          // offset alias hits
        access(1'b0, 32'h0000_1010, '0, "R3");          // plain hit
        access(1'b0, 32'h0000_1010 + SPAN, '0, "R6");   // same index, other tag
        access(1'b0, 32'h0000_1010, '0, "R6");          // evicted, misses again
        access(1'b0, 32'h0000_1010, '0, "R5");          // filled, hits
        access(1'b1, 32'h0000_201C, 32'hCAFE_0001, "R8"); // store miss
        access(1'b0, 32'h0000_201C, '0, "R7");
        access(1'b1, 32'h0000_1012, 32'hBEEF_0002, "R7"); // store hit, offset set
        access(1'b0, 32'h0000_1010, '0, "R7");
        access(1'b1, 32'h0000_1010 + SPAN, 32'h1234_5678, "R8"); // evict by store
        access(1'b0, 32'h0000_1010, '0, "R8");          // refetch written-through word
        access(1'b0, 32'h0000_1010 + SPAN, '0, "R6");
        for (int i = 0; i < NLINE; i++) access(1'b0, 32'h0004_0000 + 32'(i) * 4, '0, "R4");
        for (int i = 0; i < NLINE; i++) access(1'b0, 32'h0004_0000 + 32'(i) * 4, '0, "R3");
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!ended) begin
            ended = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule